// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block guards a battery-backed static memory while its supply ramps up or down. External comparators report two flags: whether the supply is under the power-fail threshold, and whether it is under the lower switch-over level. The block brings both flags into the clock domain through a short synchronizer. It then decides when the memory must refuse writes and keep its data pins released, when the battery must feed the array, and when the system may use the memory again. One comparator threshold or another only changes where the flag trips. The digital sequence is the same for both.

A bus cycle that is already running when the failure is detected may finish, but only for a bounded number of clocks. Once the supply is good again, protection stays on for a recovery window before the ready flag rises. The recovery window restarts whenever the supply dips again before it has finished. The battery stays isolated until the supply has been seen valid once.

The controller has four states. `ST_HOLD` is protected and waits for a valid supply. `ST_RECOV` is protected and counts the recovery window. `ST_RUN` is normal operation. `ST_GRACE` lets an in-flight cycle finish.

Its transitions are:
- `HOLD->RECOV` when the synchronized supply is valid.
- `RECOV->HOLD` when the supply fails again.
- `RECOV->RUN` when the recovery window expires.
- `RUN->GRACE` when a failure is seen while a cycle is active.
- `RUN->HOLD` when a failure is seen with the bus idle.
- `GRACE->HOLD` when the cycle ends or the grace window expires.

Reset enters `ST_HOLD`.

Top module: `pfws_seq`

## Requirements
- R1: While reset is asserted, and until the supply is seen valid, `wr_protect` and `io_block` are 1 and `batt_sel` and `ready` are 0.
- R2: With `cyc_active` low, a rise of `below_pf` sets `wr_protect` within SYNC_STAGES+1 clocks. With the default two stages, `wr_protect` is still 0 after the second clock edge and is 1 after the third.
- R3: If `cyc_active` is high in the cycle the synchronized failure is first seen in `ST_RUN`, protection stays off during grace. Protection is on one clock after `cyc_active` falls.
- R4: The grace window lasts exactly GRACE_CYC clocks. A cycle still active at its end is cut off and `wr_protect` becomes 1.
- R5: A cycle that starts after the failure has been detected is never granted. `wr_protect` and `io_block` stay 1 whatever `cyc_active` does.
- R6: `batt_sel` is 1 only when the synchronized `below_so` is 1 and the supply has been seen valid at least once since reset. The armed state is sticky, and `batt_sel` follows `below_so` with SYNC_STAGES clocks of delay.
- R7: After `below_pf` falls, `ready` rises after SYNC_STAGES+1+RECOV_CYC clocks, and protection clears with it.
- R8: If the synchronized supply fails during recovery, the controller returns to `ST_HOLD`. The full recovery window then counts again from the next valid supply.
- R9: `ready` is 1 only in `ST_RUN` while the synchronized supply is valid. It is never 1 while `wr_protect` is 1.
- R10: `io_block` equals `wr_protect` in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| below_pf | input | 1 | Comparator flag: supply under power-fail threshold |
| below_so | input | 1 | Comparator flag: supply under switch-over level |
| cyc_active | input | 1 | Synchronous flag: a memory bus cycle is in progress |
| wr_protect | output | 1 | 1 = memory writes blocked |
| io_block | output | 1 | 1 = data pins released and inputs ignored |
| batt_sel | output | 1 | 1 = battery feeds the array |
| ready | output | 1 | 1 = memory usable |

## Verification
The assertions take for granted that `below_so` is only asserted while `below_pf` is asserted, since the switch-over level lies below the power-fail threshold. They also take for granted that `cyc_active` is already synchronous to `clk`. The random stimulus keeps to these assumptions in three ways. It raises `below_so` only while `below_pf` is high. It clears `below_so` in the same cycle that `below_pf` falls. It drives `cyc_active` on the falling edge. Directed sequences cover the grace expiry, an early cycle end, a late cycle start and a recovery restart.

// File: rtl/pfws_pkg.sv
package pfws_pkg;
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_RECOV = 2'd1,
        ST_RUN   = 2'd2,
        ST_GRACE = 2'd3
    } pfws_state_t;
endpackage

// File: rtl/pfws_sync.sv
module pfws_sync #(
    parameter int            STAGES  = 2,
    parameter int            W       = 2,
    parameter logic [W-1:0]  RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) begin
                stg[k] <= stg[k-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pfws_timer.sv
module pfws_timer #(
    parameter int LIMIT = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    assign expire = run && (cnt == W'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + W'(1);
        end
    end

    // window counter never passes its limit (R4)
    p_cnt_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < W'(LIMIT));
endmodule

// File: rtl/pfws_batt.sv
module pfws_batt (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic so_s,
    output logic batt_sel
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (supply_ok) begin
            armed <= 1'b1;
        end
    end

    assign batt_sel = armed && so_s;

    // first-power flag never clears until reset (R6)
    p_arm_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);
endmodule

// File: rtl/pfws_seq.sv
module pfws_seq
    import pfws_pkg::*;
#(
    parameter int GRACE_CYC   = 20000,
    parameter int RECOV_CYC   = 16000000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic below_pf,
    input  logic below_so,
    input  logic cyc_active,
    output logic wr_protect,
    output logic io_block,
    output logic batt_sel,
    output logic ready
);
    logic [1:0]  flags_s;
    logic        pf_s;
    logic        so_s;
    logic        grace_exp;
    logic        recov_exp;
    pfws_state_t st_q;
    pfws_state_t st_d;

    pfws_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({below_so, below_pf}),
        .q     (flags_s)
    );

    assign pf_s = flags_s[0];
    assign so_s = flags_s[1];

    pfws_timer #(.LIMIT(GRACE_CYC)) u_grace_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st_q == ST_GRACE),
        .expire (grace_exp)
    );

    pfws_timer #(.LIMIT(RECOV_CYC)) u_recov_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st_q == ST_RECOV),
        .expire (recov_exp)
    );

    pfws_batt u_batt (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (!pf_s),
        .so_s      (so_s),
        .batt_sel  (batt_sel)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HOLD:  if (!pf_s) st_d = ST_RECOV;
            ST_RECOV: begin
                if (pf_s)           st_d = ST_HOLD;
                else if (recov_exp) st_d = ST_RUN;
            end
            ST_RUN:   if (pf_s) st_d = cyc_active ? ST_GRACE : ST_HOLD;
            ST_GRACE: if (!cyc_active || grace_exp) st_d = ST_HOLD;
            default:  st_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HOLD;
        else        st_q <= st_d;
    end

    always_comb begin
        wr_protect = !((st_q == ST_RUN) || (st_q == ST_GRACE));
        io_block   = wr_protect;
        ready      = (st_q == ST_RUN) && !pf_s;
    end

    p_idle_fail_protects_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && pf_s && !cyc_active) |=> wr_protect);

    p_grace_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_GRACE && !cyc_active) |=> wr_protect);

    p_no_late_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD) |=> (st_q != ST_GRACE));

    p_so_within_pf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        so_s |-> pf_s);

    p_recov_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RECOV && pf_s) |=> (st_q == ST_HOLD));

    p_ready_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!wr_protect && !io_block));
endmodule

// File: tb/pfws_seq_test.sv
module pfws_seq_test;
    localparam int G = 6;
    localparam int R = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic below_pf = 1'b1;
    logic below_so = 1'b1;
    logic cyc_active = 1'b0;
    logic wr_protect, io_block, batt_sel, ready;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    pfws_seq #(.GRACE_CYC(G), .RECOV_CYC(R), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .below_pf(below_pf), .below_so(below_so),
        .cyc_active(cyc_active), .wr_protect(wr_protect), .io_block(io_block),
        .batt_sel(batt_sel), .ready(ready)
    );

    // bench reference model: 0 hold, 1 recovering, 2 running, 3 grace
    logic m_p1, m_p2, m_s1, m_s2, m_arm;
    int   m_st, m_cnt;

    function automatic int nxt_st(int st, logic pf, logic cyc, int cnt);
        case (st)
            0: return pf ? 0 : 1;
            1: return pf ? 0 : ((cnt == R - 1) ? 2 : 1);
            2: return pf ? (cyc ? 3 : 0) : 2;
            default: return (!cyc || cnt == G - 1) ? 0 : 3;
        endcase
    endfunction

    function automatic int nxt_cnt(int st, int cnt);
        if (st == 1) return (cnt == R - 1) ? 0 : cnt + 1;
        if (st == 3) return (cnt == G - 1) ? 0 : cnt + 1;
        return 0;
    endfunction

    function automatic logic exp_prot(int st);
        return !(st == 2 || st == 3);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_p1 <= 1'b1; m_p2 <= 1'b1; m_s1 <= 1'b1; m_s2 <= 1'b1;
            m_arm <= 1'b0; m_st <= 0; m_cnt <= 0;
        end else begin
            m_p1 <= below_pf; m_p2 <= m_p1;
            m_s1 <= below_so; m_s2 <= m_s1;
            m_arm <= m_arm | !m_p2;
            m_st <= nxt_st(m_st, m_p2, cyc_active, m_cnt);
            m_cnt <= nxt_cnt(m_st, m_cnt);
        end
    end

    task automatic chk(string req, string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic power_up();
        below_so = 1'b0; below_pf = 1'b0;
        tick(3 + R);
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        tick(3);
        chk("R1", "wr_protect in reset", wr_protect, 1'b1);
        chk("R1", "ready in reset", ready, 1'b0);
        rst_n = 1'b1;
        tick(4);
        chk("R1", "wr_protect after reset", wr_protect, 1'b1);
        chk("R1", "io_block after reset", io_block, 1'b1);
        chk("R6", "batt_sel unarmed", batt_sel, 1'b0);

        // R7 first power-up
        below_so = 1'b0; below_pf = 1'b0;
        tick(2 + R);
        chk("R7", "ready before window end", ready, 1'b0);
        chk("R7", "protect before window end", wr_protect, 1'b1);
        tick(1);
        chk("R7", "ready after window", ready, 1'b1);
        chk("R7", "protect cleared", wr_protect, 1'b0);

        // R2 idle failure
        below_pf = 1'b1;
        tick(2);
        chk("R2", "protect not yet", wr_protect, 1'b0);
        chk("R9", "ready drops with synced fail", ready, 1'b0);
        tick(1);
        chk("R2", "protect set", wr_protect, 1'b1);
        chk("R10", "io_block with protect", io_block, 1'b1);

        // R5 late cycle
        cyc_active = 1'b1;
        tick(3);
        chk("R5", "late cycle protect", wr_protect, 1'b1);
        chk("R5", "late cycle io_block", io_block, 1'b1);
        cyc_active = 1'b0;

        // R6 battery switch
        below_so = 1'b1;
        tick(1);
        chk("R6", "batt_sel delay", batt_sel, 1'b0);
        tick(1);
        chk("R6", "batt_sel on", batt_sel, 1'b1);
        below_so = 1'b0;
        tick(2);
        chk("R6", "batt_sel off", batt_sel, 1'b0);

        power_up();
        chk("R7", "ready after second power-up", ready, 1'b1);

        // R4 grace expiry
        cyc_active = 1'b1; below_pf = 1'b1;
        tick(2 + G);
        chk("R4", "grace still open", wr_protect, 1'b0);
        tick(1);
        chk("R4", "grace cut off", wr_protect, 1'b1);
        cyc_active = 1'b0;

        // R8 restart of recovery
        below_pf = 1'b0;
        tick(3 + R / 2);
        below_pf = 1'b1;
        tick(1);
        below_pf = 1'b0;
        tick(2 + R);
        chk("R8", "ready held by restart", ready, 1'b0);
        tick(1);
        chk("R8", "ready after full restart", ready, 1'b1);

        // R3 early cycle end
        cyc_active = 1'b1; below_pf = 1'b1;
        tick(4);
        chk("R3", "grace open", wr_protect, 1'b0);
        cyc_active = 1'b0;
        tick(1);
        chk("R3", "protect after cycle end", wr_protect, 1'b1);

        // random phase against the bench model
        for (int i = 0; i < 4000; i++) begin
            chk("R3", "wr_protect random", wr_protect, exp_prot(m_st));
            chk("R10", "io_block random", io_block, exp_prot(m_st));
            chk("R6", "batt_sel random", batt_sel, m_arm & m_s2);
            chk("R9", "ready random", ready, (m_st == 2) && !m_p2);
            if (below_pf) begin
                if ($urandom_range(39) == 0) begin below_pf = 1'b0; below_so = 1'b0; end
                else if ($urandom_range(9) == 0) below_so = ~below_so;
            end else if ($urandom_range(59) == 0) begin
                below_pf = 1'b1;
            end
            if ($urandom_range(3) == 0) cyc_active = ~cyc_active;
            tick(1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule